// File: doc/BRIEF.md
# Host Block-Erase Sequencer

This block runs one flash block erase from the host side over a simple register bus. A one-cycle `start_i` pulse latches a die select bit and a block number. The sequencer then writes the die and block selection word and the buffer selection word, and issues the erase command. It polls the interrupt register until the ready bit is set, and then reads the controller status to find out whether the erase failed. If automatic interrupt mode is off, it clears the interrupt. Last, it reads the write-protection status word. At the end it pulses `done_o` and holds an error flag, a timeout flag and the captured protection word. A failed block is only reported. Remapping it is left to the software above.

Each bus access takes exactly one cycle: `bus_req_o` is high for that cycle, and `bus_we_o` tells a write from a read. For a read, the data on `bus_rdata_i` is sampled in the cycle after the strobe. Polling stops after a fixed number of reads, and the operation then ends with an error.

Top module: `blk_erase_seq`

## Requirements
- R1: Out of reset the block is idle: `busy_o`, `done_o`, `bus_req_o`, `error_o` and `timeout_o` are 0 and `prot_o` is 0.
- R2: In the first cycle after an accepted start, the block writes address F100h with the selection word: bit 15 is the die bit and bits 14:0 are the zero-extended block number. In the next cycle it writes F101h with the die bit in bit 15 and all other bits 0. In the cycle after that it writes 0094h to F220h.
- R3: After the command, the block reads F241h. It samples the data one cycle later and issues another read of F241h only while bit 15 of that data is 0, so that read strobes fall on every other cycle.
- R4: Once bit 15 of F241h is set, the block reads F240h. It sets `error_o` exactly when bit 10 of the returned word is 1, and all other bits are ignored.
- R5: After the status read, the block writes 0000h to F241h when `auto_int_i` was 0 at start. The write is skipped when `auto_int_i` was 1.
- R6: The block then reads F24Eh, and `prot_o` takes the whole 16-bit returned word.
- R7: If MAX_POLLS reads of F241h all return bit 15 clear, the operation ends with `error_o` and `timeout_o` set, and no further bus access is made. A ready bit on the last allowed read is not a timeout.
- R8: `done_o` is high for exactly one cycle per operation, in the cycle after the last bus access completes. `error_o`, `timeout_o` and `prot_o` then hold until the next accepted start, which clears them.
- R9: A start pulse while `busy_o` is high is ignored: the bus sequence and the latched block number are unchanged, and no extra `done_o` pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to start an erase |
| die_i | input | 1 | Die select bit, latched at start |
| block_i | input | BLK_W | Block number, latched at start |
| auto_int_i | input | 1 | Automatic interrupt mode, latched at start; skips the clear |
| bus_req_o | output | 1 | One-cycle access strobe |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 16 | Register address |
| bus_wdata_o | output | 16 | Write data |
| bus_rdata_i | input | 16 | Read data, valid the cycle after a read strobe |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Erase failure or poll timeout |
| timeout_o | output | 1 | Ready bit never seen within MAX_POLLS reads |
| prot_o | output | 16 | Captured write-protection status |

## Verification
The assertions check, on every cycle, the bus timing rules: strobes occur only while busy, a read strobe is never followed directly by another strobe, and any write to F241h carries zero. They also check that a new operation always opens with the F100h write, that `done_o` is a single-cycle pulse, that results stay stable while idle, and that a timeout always implies an error. Whether the full ordering and data are right can only be shown by the bench's scenarios: the selection words, the poll counts (including a ready bit on exactly the last allowed poll), the status-bit decoding with noise bits, the skipped clear and the ignored mid-operation start.

// File: rtl/blk_erase_pkg.sv
package blk_erase_pkg;
  localparam int DATA_W = 16;
  localparam int SEL_BLK_W = 15;

  localparam logic [15:0] ADDR_SEL  = 16'hF100;
  localparam logic [15:0] ADDR_BUF  = 16'hF101;
  localparam logic [15:0] ADDR_CMD  = 16'hF220;
  localparam logic [15:0] ADDR_STAT = 16'hF240;
  localparam logic [15:0] ADDR_INT  = 16'hF241;
  localparam logic [15:0] ADDR_PROT = 16'hF24E;
  localparam logic [15:0] CMD_ERASE = 16'h0094;
  localparam int INT_BIT = 15;
  localparam int ERR_BIT = 10;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WR_SEL,
    ST_WR_BUF,
    ST_WR_CMD,
    ST_POLL_RD,
    ST_POLL_CHK,
    ST_STAT_RD,
    ST_STAT_CHK,
    ST_CLR_WR,
    ST_PROT_RD,
    ST_PROT_CHK,
    ST_FIN
  } seq_state_e;
endpackage

// File: rtl/blk_erase_ctrl.sv
module blk_erase_ctrl
  import blk_erase_pkg::*;
#(
  parameter int MAX_POLLS = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       auto_int_i,
  input  logic       int_flag_i,
  output seq_state_e state_o,
  output logic       timeout_evt_o
);
  localparam int CNT_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam logic [CNT_W-1:0] LAST_POLL = CNT_W'(MAX_POLLS - 1);

  seq_state_e state_q, state_d;
  logic [CNT_W-1:0] poll_q, poll_d;
  logic auto_q, auto_d;
  logic last_poll;

  assign last_poll     = (poll_q == LAST_POLL);
  assign timeout_evt_o = (state_q == ST_POLL_CHK) && !int_flag_i && last_poll;
  assign state_o       = state_q;

  always_comb begin
    state_d = state_q;
    poll_d  = poll_q;
    auto_d  = auto_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_WR_SEL;
        poll_d  = '0;
        auto_d  = auto_int_i;
      end
      ST_WR_SEL:  state_d = ST_WR_BUF;
      ST_WR_BUF:  state_d = ST_WR_CMD;
      ST_WR_CMD:  state_d = ST_POLL_RD;
      ST_POLL_RD: state_d = ST_POLL_CHK;
      ST_POLL_CHK: begin
        if (int_flag_i) state_d = ST_STAT_RD;
        else if (last_poll) state_d = ST_FIN;
        else begin
          poll_d  = poll_q + 1'b1;
          state_d = ST_POLL_RD;
        end
      end
      ST_STAT_RD:  state_d = ST_STAT_CHK;
      ST_STAT_CHK: state_d = auto_q ? ST_PROT_RD : ST_CLR_WR;
      ST_CLR_WR:   state_d = ST_PROT_RD;
      ST_PROT_RD:  state_d = ST_PROT_CHK;
      ST_PROT_CHK: state_d = ST_FIN;
      ST_FIN:      state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      poll_q  <= '0;
      auto_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      poll_q  <= poll_d;
      auto_q  <= auto_d;
    end
  end
endmodule

// File: rtl/blk_erase_bus.sv
module blk_erase_bus
  import blk_erase_pkg::*;
#(
  parameter int BLK_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             die_i,
  input  logic [BLK_W-1:0] block_i,
  input  seq_state_e       state_i,
  output logic             req_o,
  output logic             we_o,
  output logic [15:0]      addr_o,
  output logic [15:0]      wdata_o
);
  logic [SEL_BLK_W-1:0] blk_ext;
  logic [15:0] sel_q;

  // fit block number into the selection field
  generate
    if (BLK_W < SEL_BLK_W) begin : g_pad
      assign blk_ext = {{(SEL_BLK_W - BLK_W){1'b0}}, block_i};
    end else begin : g_cut
      assign blk_ext = block_i[SEL_BLK_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else if (state_i == ST_IDLE && start_i) sel_q <= {die_i, blk_ext};
  end

  always_comb begin
    req_o   = 1'b0;
    we_o    = 1'b0;
    addr_o  = '0;
    wdata_o = '0;
    unique case (state_i)
      ST_WR_SEL:  begin req_o = 1'b1; we_o = 1'b1; addr_o = ADDR_SEL; wdata_o = sel_q; end
      ST_WR_BUF:  begin req_o = 1'b1; we_o = 1'b1; addr_o = ADDR_BUF; wdata_o = {sel_q[15], 15'b0}; end
      ST_WR_CMD:  begin req_o = 1'b1; we_o = 1'b1; addr_o = ADDR_CMD; wdata_o = CMD_ERASE; end
      ST_POLL_RD: begin req_o = 1'b1; addr_o = ADDR_INT; end
      ST_STAT_RD: begin req_o = 1'b1; addr_o = ADDR_STAT; end
      ST_CLR_WR:  begin req_o = 1'b1; we_o = 1'b1; addr_o = ADDR_INT; end
      ST_PROT_RD: begin req_o = 1'b1; addr_o = ADDR_PROT; end
      default: ;
    endcase
  end
endmodule

// File: rtl/blk_erase_result.sv
module blk_erase_result
  import blk_erase_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  seq_state_e  state_i,
  input  logic [15:0] rdata_i,
  input  logic        timeout_evt_i,
  output logic        error_o,
  output logic        timeout_o,
  output logic [15:0] prot_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      error_o   <= 1'b0;
      timeout_o <= 1'b0;
      prot_o    <= '0;
    end else if (state_i == ST_IDLE && start_i) begin
      error_o   <= 1'b0;
      timeout_o <= 1'b0;
      prot_o    <= '0;
    end else begin
      if (timeout_evt_i) begin
        error_o   <= 1'b1;
        timeout_o <= 1'b1;
      end
      if (state_i == ST_STAT_CHK && rdata_i[ERR_BIT]) error_o <= 1'b1;
      if (state_i == ST_PROT_CHK) prot_o <= rdata_i;
    end
  end
endmodule

// File: rtl/blk_erase_seq.sv
module blk_erase_seq
  import blk_erase_pkg::*;
#(
  parameter int BLK_W     = 10,
  parameter int MAX_POLLS = 1024
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             die_i,
  input  logic [BLK_W-1:0] block_i,
  input  logic             auto_int_i,
  output logic             bus_req_o,
  output logic             bus_we_o,
  output logic [15:0]      bus_addr_o,
  output logic [15:0]      bus_wdata_o,
  input  logic [15:0]      bus_rdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             error_o,
  output logic             timeout_o,
  output logic [15:0]      prot_o
);
  seq_state_e state;
  logic timeout_evt;

  blk_erase_ctrl #(.MAX_POLLS(MAX_POLLS)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .auto_int_i   (auto_int_i),
    .int_flag_i   (bus_rdata_i[INT_BIT]),
    .state_o      (state),
    .timeout_evt_o(timeout_evt)
  );

  blk_erase_bus #(.BLK_W(BLK_W)) u_bus (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .die_i  (die_i),
    .block_i(block_i),
    .state_i(state),
    .req_o  (bus_req_o),
    .we_o   (bus_we_o),
    .addr_o (bus_addr_o),
    .wdata_o(bus_wdata_o)
  );

  blk_erase_result u_res (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .state_i      (state),
    .rdata_i      (bus_rdata_i),
    .timeout_evt_i(timeout_evt),
    .error_o      (error_o),
    .timeout_o    (timeout_o),
    .prot_o       (prot_o)
  );

  assign busy_o = (state != ST_IDLE);
  assign done_o = (state == ST_FIN);
endmodule

// File: rtl/blk_erase_seq_chk.sv
module blk_erase_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        bus_req_o,
  input logic        bus_we_o,
  input logic [15:0] bus_addr_o,
  input logic [15:0] bus_wdata_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        error_o,
  input logic        timeout_o
);
  a_r1_req_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> busy_o);

  a_r2_opens_with_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (bus_req_o && bus_we_o && bus_addr_o == 16'hF100));

  a_r3_read_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_we_o) |=> !bus_req_o);

  a_r5_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_we_o && bus_addr_o == 16'hF241) |-> (bus_wdata_o == 16'h0000));

  a_r7_timeout_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> error_o);

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o)) |-> ($stable(error_o) && $stable(timeout_o)));

  a_r9_rise_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
endmodule

bind blk_erase_seq blk_erase_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .bus_req_o  (bus_req_o),
  .bus_we_o   (bus_we_o),
  .bus_addr_o (bus_addr_o),
  .bus_wdata_o(bus_wdata_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .error_o    (error_o),
  .timeout_o  (timeout_o)
);

// File: tb/blk_erase_seq_tb.sv
module blk_erase_seq_tb;
  localparam int BLK_W = 10;
  localparam int MAXP  = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 1'b0, die = 1'b0, auto_int = 1'b0;
  logic [BLK_W-1:0] blk = '0;
  logic req, we, busy, done, err, tmo;
  logic [15:0] addr, wdata, prot;
  logic [15:0] rdata = '0;

  always #4 clk = ~clk;

  blk_erase_seq #(.BLK_W(BLK_W), .MAX_POLLS(MAXP)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .die_i(die), .block_i(blk),
    .auto_int_i(auto_int), .bus_req_o(req), .bus_we_o(we), .bus_addr_o(addr),
    .bus_wdata_o(wdata), .bus_rdata_i(rdata), .busy_o(busy), .done_o(done),
    .error_o(err), .timeout_o(tmo), .prot_o(prot)
  );

  int checks = 0, fails = 0, done_cnt = 0, cyc = 0;

  typedef struct { logic w; logic [15:0] a; logic [15:0] d; string tag; } txn_t;
  txn_t exp_q[$];

  // flash register model
  int m_ready_at = 0;
  int m_reads = 0;
  logic m_err = 1'b0;
  logic [15:0] m_prot = '0;

  always @(posedge clk) begin
    if (req && !we) begin
      case (addr)
        16'hF241: begin
          m_reads <= m_reads + 1;
          rdata <= (m_ready_at != 0 && m_reads + 1 >= m_ready_at) ? 16'h8000 : 16'h7FFF;
        end
        16'hF240: rdata <= m_err ? 16'h8401 : 16'h8001;
        16'hF24E: rdata <= m_prot;
        default:  rdata <= 16'hDEAD;
      endcase
    end else rdata <= 16'h0000;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: compare each bus strobe with the scoreboard
  always @(negedge clk) begin
    cyc++;
    if (rst_ni && done) done_cnt++;
    if (rst_ni && req) begin
      if (exp_q.size() == 0) check(1'b0, "R7", "unexpected access", {16'h0, addr}, 32'h0);
      else begin
        txn_t e;
        e = exp_q.pop_front();
        check(we == e.w && addr == e.a, e.tag, "access addr/we", {15'h0, we, addr}, {15'h0, e.w, e.a});
        if (e.w) check(wdata == e.d, e.tag, "write data", {16'h0, wdata}, {16'h0, e.d});
      end
    end
  end

  task automatic push(input logic w, input logic [15:0] a, input logic [15:0] d, input string tag);
    txn_t t;
    t.w = w; t.a = a; t.d = d; t.tag = tag;
    exp_q.push_back(t);
  endtask

  task automatic run_erase(input logic d_in, input logic [BLK_W-1:0] b_in, input logic au,
                           input int ready_at, input logic e_in, input logic [15:0] p_in,
                           input bit poke_busy, input string tag);
    int n_polls, wait_c, d0;
    bit exp_to;
    exp_to  = (ready_at == 0 || ready_at > MAXP);
    n_polls = exp_to ? MAXP : ready_at;
    m_ready_at = ready_at; m_reads = 0; m_err = e_in; m_prot = p_in;
    push(1'b1, 16'hF100, {d_in, 5'b0, b_in}, "R2");
    push(1'b1, 16'hF101, {d_in, 15'b0}, "R2");
    push(1'b1, 16'hF220, 16'h0094, "R2");
    for (int i = 0; i < n_polls; i++) push(1'b0, 16'hF241, 16'h0, "R3");
    if (!exp_to) begin
      push(1'b0, 16'hF240, 16'h0, "R4");
      if (!au) push(1'b1, 16'hF241, 16'h0000, "R5");
      push(1'b0, 16'hF24E, 16'h0, "R6");
    end
    d0 = done_cnt;
    @(negedge clk);
    die = d_in; blk = b_in; auto_int = au; start = 1'b1;
    @(negedge clk);
    start = 1'b0; die = ~d_in; blk = ~b_in; auto_int = ~au;
    if (poke_busy) begin
      repeat (4) @(negedge clk);
      check(busy == 1'b1, "R9", "busy during op", {31'h0, busy}, 32'h1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_c = 0;
    while (!done && wait_c < 300) begin @(negedge clk); wait_c++; end
    check(done == 1'b1, "R8", "done seen", {31'h0, done}, 32'h1);
    check(exp_q.size() == 0, tag, "all accesses issued", exp_q.size(), 32'h0);
    exp_q.delete();
    check(err == (e_in | exp_to), exp_to ? "R7" : "R4", "error", {31'h0, err}, {31'h0, e_in | exp_to});
    check(tmo == exp_to, "R7", "timeout", {31'h0, tmo}, {31'h0, exp_to});
    check(prot == (exp_to ? 16'h0 : p_in), "R6", "prot", {16'h0, prot}, {16'h0, exp_to ? 16'h0 : p_in});
    repeat (5) @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R8", "done pulse ended", {30'h0, busy, done}, 32'h0);
    check(done_cnt == d0 + 1, poke_busy ? "R9" : "R8", "done count", done_cnt - d0, 32'h1);
    check(err == (e_in | exp_to) && prot == (exp_to ? 16'h0 : p_in), "R8", "results held",
          {15'h0, err, prot}, {15'h0, e_in | exp_to, exp_to ? 16'h0 : p_in});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && req == 0 && err == 0 && tmo == 0 && prot == 0, "R1",
          "reset state", {26'h0, busy, done, req, err, tmo, |prot}, 32'h0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 0 && req == 0, "R1", "idle after reset", {30'h0, busy, req}, 32'h0);
    run_erase(1'b0, 10'h005, 1'b0, 1,  1'b0, 16'h00A5, 1'b0, "R3");
    run_erase(1'b1, 10'h3FF, 1'b1, 4,  1'b1, 16'h1234, 1'b0, "R5");
    run_erase(1'b0, 10'h155, 1'b0, 2,  1'b1, 16'hFFFF, 1'b0, "R4");
    run_erase(1'b1, 10'h001, 1'b0, 0,  1'b0, 16'hBEEF, 1'b0, "R7");
    run_erase(1'b0, 10'h2AA, 1'b0, 3,  1'b0, 16'h0F0F, 1'b1, "R9");
    run_erase(1'b1, 10'h100, 1'b1, MAXP, 1'b0, 16'h5A5A, 1'b0, "R7");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    checks++; fails++;
    $display("FAIL watchdog expired R8 actual=%0d expected=<20000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule